// File: doc/BRIEF.md
# Serial Flash Slave Model with Write Protection

This block is the device side of a small serial NOR flash. A host drives an active-low select, a serial clock and a data line. The block decodes byte-wide commands, keeps a status byte, and holds a byte-wide storage array that starts fully erased. The array is split into four equal sectors, and each sector is one 256-byte page at the default size. The serial lines are oversampled by the system clock. Data is taken on a rising serial clock edge, and reply bits change on the falling edge, so the block works in SPI mode 0.

Every array change runs as a self-timed job: write-status, page program, sector erase and bulk erase. The busy flag stays up for a length set by a parameter for each job type. A job starts only if the write-enable latch is set and the target is outside the region fenced off by the two protect bits. Program data collects in a page buffer that wraps inside the page. The array is touched only after the select rises on a byte boundary, and programming can only clear bits. The block is a verification model for checking flash host controllers in simulation or on an FPGA test rig.

Top module: `sfl_slave`

## Requirements
- R1: After reset the status byte reads 0x00, every array byte reads 0xFF, and the data output is low while the select is high.
- R2: Opcode 0x06 sets the latch (status bit 1) and opcode 0x04 clears it. Program, erase and write-status commands sent with the latch clear leave the array and the status unchanged.
- R3: An accepted program, erase or write-status sets the busy flag (status bit 0) from the select's rising edge for the configured job length. When the job ends, the busy flag and the latch are both clear.
- R4: Page program (opcode 0x02, three address bytes MSB first, then data) stores old AND new in each addressed byte. The other bytes of the page do not change.
- R5: Page program data running past the end of the page wraps the column back to column 0 of the same page. A later byte for a column replaces an earlier one.
- R6: Protect bits are status bits 3:2. Code 0 protects nothing, 1 protects sector 3, 2 protects sectors 2 and 3, and 3 protects all four. A program or sector erase aimed at a protected sector, or a bulk erase with a nonzero code, is refused with the latch left set.
- R7: Write-status (opcode 0x01) copies bits 3:2 of its data byte into the protect bits.
- R8: Read (opcode 0x03, three address bytes) returns bytes MSB first from the address upward and wraps at the array end. Address bits above the array size are ignored.
- R9: Opcode 0xAB followed by three dummy bytes returns the device ID byte (0x12 by default), repeated until the select rises.
- R10: Sector erase (opcode 0xD8, three address bytes) sets every byte of the addressed sector to 0xFF. Bulk erase (opcode 0xC7) does the same to the whole array.
- R11: A select rising part-way through a byte discards the command without touching the array, and it clears the latch.
- R12: While busy, every command except read-status (opcode 0x05) is ignored. Read-status returns the current status byte repeatedly until the select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |

## Verification
The bench aims at wrapping and partial-page program:
- A model that fills the page linearly would corrupt the next page.
- A model that writes the whole page would wipe bytes that were not addressed.
- A model that ORs data in would set bits that should stay clear.

It steps through every protect code against sectors just inside and just outside the fence. A wrong boundary either damages the fenced data or refuses a legal program. Commands are sent while the block is busy, and the latch is watched across that window; a model that decodes those commands would change the latch or the array mid-job. An aborted program ending mid-byte checks that nothing lands in the array and that the latch drops.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_PP   = 8'h02;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_RDID = 8'hAB;
    localparam logic [7:0] OP_BE   = 8'hC7;
    localparam logic [7:0] OP_SE   = 8'hD8;

    // Protect encoding is defined for exactly four sectors.
    localparam int SECT_W = 2;

    typedef enum logic [1:0] {
        JOB_WRSR,
        JOB_PP,
        JOB_SE,
        JOB_BE
    } job_e;

    typedef struct packed {
        logic [3:0] rsvd;
        logic [1:0] guard;
        logic       wel;
        logic       wip;
    } status_t;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic sector_locked(input logic [1:0] guard,
                                           input logic [SECT_W-1:0] sect);
        logic hit;
        unique case (guard)
            2'd0: hit = 1'b0;
            2'd1: hit = (sect == 2'd3);
            2'd2: hit = sect[1];
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/sfl_link.sv
// Serial front end: edge detection, byte assembly and reply shifting.
module sfl_link (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       byte_vld,
    output logic [7:0] rx_byte,
    output logic [2:0] nbytes,
    output logic [2:0] bit_pos,
    output logic       tx_take,
    output logic       cs_rise
);
    logic       sclk_q, cs_q;
    logic [2:0] bit_q, cnt_q;
    logic [6:0] sh_q;
    logic [7:0] obuf_q;
    logic       active, sclk_rise, sclk_fall;

    assign active    = !cs_n;
    assign sclk_rise = active && sclk && !sclk_q;
    assign sclk_fall = active && !sclk && sclk_q;
    assign cs_rise   = cs_n && !cs_q;
    assign byte_vld  = sclk_rise && (bit_q == 3'd7);
    assign rx_byte   = {sh_q, mosi};
    assign tx_take   = sclk_fall && (bit_q == 3'd0) && (cnt_q != 3'd0);
    assign nbytes    = cnt_q;
    assign bit_pos   = bit_q;
    assign miso      = active && obuf_q[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
            bit_q  <= '0;
            cnt_q  <= '0;
            sh_q   <= '0;
            obuf_q <= '0;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
            if (!active) begin
                bit_q  <= '0;
                cnt_q  <= '0;
                obuf_q <= '0;
            end else begin
                if (sclk_rise) begin
                    sh_q  <= {sh_q[5:0], mosi};
                    bit_q <= bit_q + 3'd1;
                    if (bit_q == 3'd7 && cnt_q != 3'd7)
                        cnt_q <= cnt_q + 3'd1;
                end
                if (tx_take)
                    obuf_q <= tx_byte;
                else if (sclk_fall)
                    obuf_q <= {obuf_q[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/sfl_array.sv
// Storage array, page buffer and self-timed job engine.
module sfl_array
    import sfl_pkg::*;
#(
    parameter int MEM_AW = 10,
    parameter int PAGE_W = 8,
    parameter int PP_CYC = 300,
    parameter int SE_CYC = 400,
    parameter int BE_CYC = 1100,
    parameter int WS_CYC = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              buf_clr,
    input  logic              buf_we,
    input  logic [PAGE_W-1:0] buf_col,
    input  logic [7:0]        buf_data,
    input  logic              start,
    input  job_e              start_job,
    input  logic [MEM_AW-1:0] start_base,
    output logic              busy,
    output logic              done
);
    localparam int MEM_BYTES  = 1 << MEM_AW;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int SECT_BYTES = 1 << (MEM_AW - SECT_W);
    localparam int PP_LEN     = max_i(PP_CYC, PAGE_BYTES);
    localparam int SE_LEN     = max_i(SE_CYC, SECT_BYTES);
    localparam int BE_LEN     = max_i(BE_CYC, MEM_BYTES);
    localparam int WS_LEN     = max_i(WS_CYC, 1);
    localparam int LEN_MAX    = max_i(max_i(PP_LEN, SE_LEN), max_i(BE_LEN, WS_LEN));
    localparam int TW         = $clog2(LEN_MAX + 1);
    localparam int IW         = MEM_AW + 1;

    logic [7:0]            mem  [MEM_BYTES];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask_q;

    logic              busy_q;
    job_e              job_q;
    logic [MEM_AW-1:0] base_q;
    logic [TW-1:0]     tmr_q;
    logic [IW-1:0]     idx_q;

    logic              sw_en;
    logic [MEM_AW-1:0] sw_addr;
    logic [7:0]        sw_data;
    logic [PAGE_W-1:0] sw_col;

    assign busy    = busy_q;
    assign done    = busy_q && (tmr_q == '0);
    assign rd_data = mem[rd_addr];
    assign sw_col  = idx_q[PAGE_W-1:0];

    always_comb begin
        sw_en   = 1'b0;
        sw_addr = base_q;
        sw_data = 8'hFF;
        if (busy_q) begin
            unique case (job_q)
                JOB_PP: begin
                    sw_addr = base_q | MEM_AW'(sw_col);
                    sw_data = mem[sw_addr] & pbuf[sw_col];
                    sw_en   = (idx_q < IW'(PAGE_BYTES)) && pmask_q[sw_col];
                end
                JOB_SE: begin
                    sw_addr = base_q | idx_q[MEM_AW-1:0];
                    sw_en   = idx_q < IW'(SECT_BYTES);
                end
                JOB_BE: begin
                    sw_addr = idx_q[MEM_AW-1:0];
                    sw_en   = idx_q < IW'(MEM_BYTES);
                end
                default: sw_en = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (sw_en) begin
            mem[sw_addr] <= sw_data;
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_col] <= buf_data;
    end

    always_ff @(posedge clk) begin
        if (rst || buf_clr) pmask_q <= '0;
        else if (buf_we)    pmask_q[buf_col] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            job_q  <= JOB_WRSR;
            base_q <= '0;
            tmr_q  <= '0;
            idx_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                job_q  <= start_job;
                base_q <= start_base;
                idx_q  <= '0;
                unique case (start_job)
                    JOB_PP:  tmr_q <= TW'(PP_LEN - 1);
                    JOB_SE:  tmr_q <= TW'(SE_LEN - 1);
                    JOB_BE:  tmr_q <= TW'(BE_LEN - 1);
                    default: tmr_q <= TW'(WS_LEN - 1);
                endcase
            end
        end else begin
            if (idx_q != IW'(MEM_BYTES)) idx_q <= idx_q + 1'b1;
            if (tmr_q == '0) busy_q <= 1'b0;
            else             tmr_q  <= tmr_q - 1'b1;
        end
    end
endmodule

// File: rtl/sfl_slave.sv
// Command decoder, status register and protection gate.
module sfl_slave
    import sfl_pkg::*;
#(
    parameter int         MEM_AW = 10,
    parameter int         PAGE_W = 8,
    parameter logic [7:0] DEV_ID = 8'h12,
    parameter int         PP_CYC = 300,
    parameter int         SE_CYC = 400,
    parameter int         BE_CYC = 1100,
    parameter int         WS_CYC = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic miso
);
    localparam int SECT_AW = MEM_AW - SECT_W;

    logic              byte_vld, tx_take, cs_rise;
    logic [7:0]        rx_byte, tx_byte, rd_data, op_q;
    logic [2:0]        nbytes, bit_pos;
    logic              busy, done;
    logic [MEM_AW-1:0] addr_q, addr_nx, rd_ptr_q, job_base;
    logic [PAGE_W-1:0] col_q;
    logic              wel_q;
    logic [1:0]        bp_q, bp_new_q;
    logic              buf_clr, buf_we, start, locked, cmd_ok;
    job_e              job;
    status_t           stat;

    sfl_link u_link (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .tx_byte(tx_byte), .miso(miso), .byte_vld(byte_vld),
        .rx_byte(rx_byte), .nbytes(nbytes), .bit_pos(bit_pos),
        .tx_take(tx_take), .cs_rise(cs_rise)
    );

    sfl_array #(
        .MEM_AW(MEM_AW), .PAGE_W(PAGE_W), .PP_CYC(PP_CYC),
        .SE_CYC(SE_CYC), .BE_CYC(BE_CYC), .WS_CYC(WS_CYC)
    ) u_array (
        .clk(clk), .rst(rst), .rd_addr(rd_ptr_q), .rd_data(rd_data),
        .buf_clr(buf_clr), .buf_we(buf_we), .buf_col(col_q),
        .buf_data(rx_byte), .start(start), .start_job(job),
        .start_base(job_base), .busy(busy), .done(done)
    );

    always_comb begin
        stat       = '0;
        stat.guard = bp_q;
        stat.wel   = wel_q;
        stat.wip   = busy;
    end

    always_comb begin
        addr_nx = MEM_AW'({addr_q, rx_byte});
        buf_clr = byte_vld && (nbytes == 3'd0) && (rx_byte == OP_PP) && !busy;
        buf_we  = byte_vld && (nbytes >= 3'd4) && (op_q == OP_PP) && !busy;
        tx_byte = 8'h00;
        if (op_q == OP_RDSR)
            tx_byte = stat;
        else if (!busy && nbytes >= 3'd4) begin
            if (op_q == OP_READ)      tx_byte = rd_data;
            else if (op_q == OP_RDID) tx_byte = DEV_ID;
        end
    end

    always_comb begin
        locked   = sector_locked(bp_q, addr_q[MEM_AW-1 -: SECT_W]);
        cmd_ok   = cs_rise && !busy && (bit_pos == 3'd0) && (nbytes != 3'd0) && wel_q;
        start    = 1'b0;
        job      = JOB_WRSR;
        job_base = '0;
        if (cmd_ok) begin
            unique case (op_q)
                OP_WRSR: start = (nbytes >= 3'd2);
                OP_PP: begin
                    job      = JOB_PP;
                    job_base = {addr_q[MEM_AW-1:PAGE_W], {PAGE_W{1'b0}}};
                    start    = (nbytes >= 3'd5) && !locked;
                end
                OP_SE: begin
                    job      = JOB_SE;
                    job_base = {addr_q[MEM_AW-1 -: SECT_W], {SECT_AW{1'b0}}};
                    start    = (nbytes >= 3'd4) && !locked;
                end
                OP_BE: begin
                    job   = JOB_BE;
                    start = (bp_q == 2'd0);
                end
                default: start = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q     <= '0;
            addr_q   <= '0;
            rd_ptr_q <= '0;
            col_q    <= '0;
            wel_q    <= 1'b0;
            bp_q     <= '0;
            bp_new_q <= '0;
        end else begin
            if (byte_vld) begin
                if (nbytes == 3'd0) op_q <= rx_byte;
                if (nbytes >= 3'd1 && nbytes <= 3'd3) addr_q <= addr_nx;
                if (nbytes == 3'd1) bp_new_q <= rx_byte[3:2];
                if (nbytes == 3'd3) begin
                    rd_ptr_q <= addr_nx;
                    col_q    <= addr_nx[PAGE_W-1:0];
                end
                if (buf_we) col_q <= col_q + 1'b1;
            end
            if (tx_take && op_q == OP_READ && nbytes >= 3'd4)
                rd_ptr_q <= rd_ptr_q + 1'b1;
            if (done)
                wel_q <= 1'b0;
            else if (cs_rise && !busy) begin
                if (bit_pos != 3'd0)
                    wel_q <= 1'b0;
                else if (nbytes != 3'd0 && op_q == OP_WREN)
                    wel_q <= 1'b1;
                else if (nbytes != 3'd0 && op_q == OP_WRDI)
                    wel_q <= 1'b0;
            end
            if (start && job == JOB_WRSR)
                bp_q <= bp_new_q;
        end
    end
endmodule

// File: rtl/sfl_checker.sv
module sfl_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       wip,
    input logic       wel,
    input logic [1:0] bp
);
    AST_JOB_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> $past(wel)) else $error("job started without latch"); // R2

    AST_JOB_AT_SELECT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> ($past(cs_n) && !$past(cs_n, 2))) else $error("job start off select edge"); // R3

    AST_LATCH_CLEAR_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(wip) |-> !wel) else $error("latch survived job end"); // R3

    AST_GUARD_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (wip && $past(wip)) |-> $stable(bp)) else $error("protect bits moved while busy"); // R12

    AST_LATCH_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (wip && $past(wip)) |-> $stable(wel)) else $error("latch moved while busy"); // R12

    AST_GUARD_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
        !$stable(bp) |-> $past(wel)) else $error("protect bits changed without latch"); // R7
endmodule

bind sfl_slave sfl_checker u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wip(busy), .wel(wel_q), .bp(bp_q)
);

// File: tb/tb_sfl_slave.sv
module tb_sfl_slave;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    wire  miso;

    always #4 clk = ~clk;

    sfl_slave dut (.clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    logic [7:0] model [1024];
    logic [7:0] pdat  [260];

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            mosi = tx[i];
            tk(2);
            rx[i] = miso;
            sclk = 1'b1;
            tk(2);
            sclk = 1'b0;
        end
    endtask

    task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic cs_lo(); cs_n = 1'b0; tk(2); endtask
    task automatic cs_hi(); tk(2); cs_n = 1'b1; tk(4); endtask

    task automatic hdr(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] r;
        xb(op, r); xb(a[23:16], r); xb(a[15:8], r); xb(a[7:0], r);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        cs_lo(); xb(op, r); cs_hi();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        cs_lo(); xb(8'h05, r); xb(8'h00, s); cs_hi();
    endtask

    task automatic st_cmp(input logic [7:0] exp, input string req, input string what);
        logic [7:0] s;
        rdsr(s);
        chk(req, what, s, exp);
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] s;
        int polls = 0;
        rdsr(s);
        while (s[0] && polls < 400) begin
            rdsr(s);
            polls++;
        end
        chk(req, "job finished", s[0], 1'b0);
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] r;
        cmd1(8'h06);
        cs_lo(); xb(8'h01, r); xb(v, r); cs_hi();
    endtask

    task automatic pp(input logic [23:0] a, input int n);
        logic [7:0] r;
        cs_lo(); hdr(8'h02, a);
        for (int i = 0; i < n; i++) xb(pdat[i], r);
        cs_hi();
    endtask

    task automatic model_pp(input logic [23:0] a, input int n);
        logic [7:0] b [256];
        logic       m [256];
        logic [7:0] c;
        for (int k = 0; k < 256; k++) m[k] = 1'b0;
        for (int i = 0; i < n; i++) begin
            c = a[7:0] + 8'(i);
            b[c] = pdat[i];
            m[c] = 1'b1;
        end
        for (int k = 0; k < 256; k++)
            if (m[k]) model[{a[9:8], 8'(k)}] = model[{a[9:8], 8'(k)}] & b[k];
    endtask

    task automatic rd_cmp(input logic [23:0] a, input int n, input string req);
        logic [7:0] r;
        cs_lo(); hdr(8'h03, a);
        for (int i = 0; i < n; i++) begin
            xb(8'h00, r);
            chk(req, "read data", r, model[10'(a + 24'(i))]);
        end
        cs_hi();
    endtask

    task automatic t_reset();
        chk("R1", "miso idle", miso, 1'b0);
        st_cmp(8'h00, "R1", "status after reset");
        rd_cmp(24'h000000, 4, "R1");
        rd_cmp(24'h0003FC, 4, "R1");
    endtask

    task automatic t_latch();
        cmd1(8'h06);
        st_cmp(8'h02, "R2", "latch set");
        cmd1(8'h04);
        st_cmp(8'h00, "R2", "latch cleared");
        pdat[0] = 8'h00;
        pp(24'h000020, 1);
        st_cmp(8'h00, "R2", "program without latch not started");
        rd_cmp(24'h000020, 1, "R2");
    endtask

    task automatic t_program();
        cmd1(8'h06);
        pdat[0] = 8'hA5; pdat[1] = 8'h3C; pdat[2] = 8'h0F;
        pp(24'h000010, 3);
        st_cmp(8'h03, "R3", "busy and latch during program");
        wait_idle("R3");
        st_cmp(8'h00, "R3", "status after program");
        model_pp(24'h000010, 3);
        rd_cmp(24'h00000E, 6, "R4");
        cmd1(8'h06);
        pdat[0] = 8'hF0; pdat[1] = 8'h0F;
        pp(24'h000011, 2);
        wait_idle("R4");
        model_pp(24'h000011, 2);
        rd_cmp(24'h000010, 3, "R4");
    endtask

    task automatic t_wrap();
        cmd1(8'h06);
        pdat[0] = 8'h11; pdat[1] = 8'h22; pdat[2] = 8'h33; pdat[3] = 8'h44;
        pp(24'h0001FE, 4);
        wait_idle("R5");
        model_pp(24'h0001FE, 4);
        rd_cmp(24'h0001FE, 2, "R5");
        rd_cmp(24'h000100, 3, "R5");
        for (int i = 0; i < 258; i++) pdat[i] = (i < 256) ? 8'(i * 3 + 1) : 8'h00;
        cmd1(8'h06);
        pp(24'h000200, 258);
        wait_idle("R5");
        model_pp(24'h000200, 258);
        rd_cmp(24'h000200, 3, "R5");
        rd_cmp(24'h0002FE, 2, "R5");
    endtask

    task automatic t_read();
        rd_cmp(24'hFC0010, 3, "R8");
        rd_cmp(24'h0003FE, 4, "R8");
    endtask

    task automatic t_protect();
        wrsr(8'h04);
        wait_idle("R7");
        st_cmp(8'h04, "R7", "protect code 1 stored");
        cmd1(8'h06);
        pdat[0] = 8'h00;
        pp(24'h000305, 1);
        st_cmp(8'h06, "R6", "sector 3 program refused");
        rd_cmp(24'h000305, 1, "R6");
        pdat[0] = 8'h81;
        pp(24'h000205, 1);
        wait_idle("R6");
        model_pp(24'h000205, 1);
        rd_cmp(24'h000205, 1, "R6");
        wrsr(8'h08);
        wait_idle("R7");
        st_cmp(8'h08, "R7", "protect code 2 stored");
        cmd1(8'h06);
        cs_lo(); hdr(8'hD8, 24'h000200); cs_hi();
        st_cmp(8'h0A, "R6", "sector 2 erase refused");
        rd_cmp(24'h000204, 2, "R6");
        wrsr(8'h0C);
        wait_idle("R7");
        cmd1(8'h06);
        cmd1(8'hC7);
        st_cmp(8'h0E, "R6", "bulk erase refused");
        pdat[0] = 8'h00;
        pp(24'h000001, 1);
        st_cmp(8'h0E, "R6", "sector 0 program refused");
        rd_cmp(24'h000000, 2, "R6");
        wrsr(8'hF3);
        wait_idle("R7");
        st_cmp(8'h00, "R7", "protect cleared by data bits 3:2");
    endtask

    task automatic t_sector_erase();
        cmd1(8'h06);
        cs_lo(); hdr(8'hD8, 24'h000150); cs_hi();
        wait_idle("R10");
        for (int k = 256; k < 512; k++) model[k] = 8'hFF;
        rd_cmp(24'h0001FC, 6, "R10");
        rd_cmp(24'h000010, 1, "R10");
    endtask

    task automatic t_busy();
        logic [7:0] r, s1, s2;
        cmd1(8'h06);
        cmd1(8'hC7);
        cs_lo(); xb(8'h05, r); xb(8'h00, s1); xb(8'h00, s2); cs_hi();
        chk("R12", "status repeat 1", s1, 8'h03);
        chk("R12", "status repeat 2", s2, 8'h03);
        cmd1(8'h04);
        st_cmp(8'h03, "R12", "disable ignored while busy");
        pdat[0] = 8'h00;
        pp(24'h000300, 1);
        wait_idle("R12");
        st_cmp(8'h00, "R3", "latch dropped after bulk erase");
        for (int k = 0; k < 1024; k++) model[k] = 8'hFF;
        rd_cmp(24'h000300, 1, "R12");
        rd_cmp(24'h000010, 2, "R10");
        rd_cmp(24'h000200, 2, "R10");
    endtask

    task automatic t_abort();
        logic [7:0] r;
        cmd1(8'h06);
        cs_lo(); hdr(8'h02, 24'h000040); xb(8'h00, r); xbits(8'h00, 4, r); cs_hi();
        st_cmp(8'h00, "R11", "latch cleared by partial byte");
        rd_cmp(24'h000040, 1, "R11");
    endtask

    task automatic t_ident();
        logic [7:0] r, a, b;
        cs_lo(); xb(8'hAB, r); xb(8'h00, r); xb(8'h00, r); xb(8'h00, r);
        xb(8'h00, a); xb(8'h00, b); cs_hi();
        chk("R9", "id first", a, 8'h12);
        chk("R9", "id repeated", b, 8'h12);
    endtask

    initial begin
        for (int k = 0; k < 1024; k++) model[k] = 8'hFF;
        tk(5);
        rst = 1'b0;
        tk(5);
        t_reset();
        t_latch();
        t_program();
        t_wrap();
        t_read();
        t_protect();
        t_sector_erase();
        t_busy();
        t_abort();
        t_ident();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R3 watchdog: actual hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule